// File: doc/BRIEF.md
# Phase-Loop Unlock Watcher

This block watches the phase-error pulse of a frequency synthesizer loop (the up and down pulses merged by an OR ahead of it) and turns it into an unlock indication a slow controller can read. A two-bit mode input picks one of three behaviours. In the stopped mode the detector output is released and nothing is flagged. In the raw mode the error pulse appears on the detector output directly, one clock late. In the windowed mode an error pulse counts as an unlock only when it is wider than half a reference-crystal period. The unlock result is then held for one to two milliseconds, so that a short slip is still seen by a controller that polls slowly.

Pulse width is measured by sampling the error on a strobe at twice the crystal rate (`smp_en`). A pulse that is still high at the second consecutive strobe is a violation. The stretch is timed by a free-running one-millisecond strobe (`ms_tick`) and a down-counter that every violation reloads. The detector pin is modelled as an enable plus an active-low level. The status bit reads 0 while the loop is unlocked.

The controller has four named states: `ST_OFF` (stopped), `ST_RAW` (passthrough), `ST_LOCK` (windowed, no unlock pending) and `ST_HOLD` (windowed, unlock being stretched). The mode code selects the state on every clock. Mode 00 leads to `ST_OFF` and mode 01 to `ST_RAW`. Entering a windowed mode from any other state leads to `ST_LOCK`. Inside a windowed mode, a violation moves `ST_LOCK` to `ST_HOLD` and keeps `ST_HOLD` where it is. The expiry of the hold count moves `ST_HOLD` back to `ST_LOCK`.

Top module: `lock_watch`

## Requirements
- R1: After reset the block is in the stopped state: `det_en`=0, `det_n`=1, `unlock`=0, `lock_ok`=1.
- R2: With `mode`=2'b00, from the clock after the mode is applied, `det_en`=0, `det_n`=1, `unlock`=0 and `lock_ok`=1, whatever `err_in`, `smp_en` and `ms_tick` do.
- R3: With `mode`=2'b01, `det_en`=1 and, one clock after `err_in` is sampled, `det_n` equals its inverse, `unlock` equals it and `lock_ok` equals its inverse.
- R4: In a windowed mode (`mode[1]`=1), a violation is `err_in` high at EDGE_SAMPLES (default 2) consecutive `smp_en` strobes. A strobe that sees `err_in` low restarts the run, so one high strobe, or highs split by a low strobe, flag nothing.
- R5: One clock after the strobe that completes a violation, `unlock`=1, `det_n`=0 (with `det_en`=1) and `lock_ok`=0.
- R6: After the last violation the unlock indication stays set through HOLD_TICKS-1 `ms_tick` strobes. It clears one clock after the HOLD_TICKS-th (default 2) strobe, which gives a hold of 1 to 2 ms.
- R7: Any violation, including one that falls on the same clock as an `ms_tick`, reloads the full hold count of HOLD_TICKS strobes.
- R8: Leaving the windowed modes discards any pending hold and any partial pulse run. On return to a windowed mode the block starts locked (`unlock`=0, `det_en`=1, `det_n`=1).
- R9: Mode codes 2'b10 and 2'b11 both select the same windowed behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Width-sampling strobe, twice the crystal rate, one clock wide |
| ms_tick | input | 1 | One-millisecond strobe, one clock wide |
| err_in | input | 1 | Phase-error pulse (up OR down) |
| mode | input | 2 | 00 stopped, 01 raw, 1x windowed |
| det_en | output | 1 | Detector pin driven (0 = released/open) |
| det_n | output | 1 | Detector pin level, low = error/unlock |
| unlock | output | 1 | Unlock flag, stretched in windowed mode |
| lock_ok | output | 1 | Status bit, 0 while unlocked |

## Verification
Every result is due exactly one clock after its cause: a mode change, a raw error level, the strobe that completes a violation, and the `ms_tick` that ends a hold each land on the output through the single state register. The bench changes inputs on falling edges and reads outputs on the next falling edge, so each check falls half a cycle after the rising edge that should have updated the output. Strobes are one clock wide, so each one is counted by exactly one edge. For the R7 same-cycle case, the two strobes are raised on the same falling edge.

// File: rtl/lw_pkg.sv
package lw_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RAW  = 2'd1,
        ST_LOCK = 2'd2,
        ST_HOLD = 2'd3
    } lw_state_e;

    localparam logic [1:0] MODE_OFF = 2'b00;
    localparam logic [1:0] MODE_RAW = 2'b01;

endpackage

// File: rtl/lw_sampler.sv
// Counts consecutive high samples of the error pulse; flags a violation on
// the strobe that completes the run.
module lw_sampler #(
    parameter int EDGE_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic smp_en,
    input  logic err_in,
    output logic viol
);
    localparam int CW = (EDGE_SAMPLES < 2) ? 1 : $clog2(EDGE_SAMPLES);
    localparam logic [CW-1:0] LAST = CW'(EDGE_SAMPLES - 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!arm) begin
            run_q <= '0;
        end else if (smp_en) begin
            if (!err_in) begin
                run_q <= '0;
            end else if (run_q != LAST) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign viol = arm && smp_en && err_in && (run_q == LAST);

endmodule

// File: rtl/lw_hold_timer.sv
// Down-counter for the unlock stretch, stepped by the millisecond strobe.
module lw_hold_timer #(
    parameter int HOLD_TICKS = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clr,
    input  logic                                load,
    input  logic                                tick,
    output logic [$clog2(HOLD_TICKS+1)-1:0]     cnt_o,
    output logic                                expire
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] FULL = HW'(HOLD_TICKS);

    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= FULL;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign expire = !clr && !load && tick && (cnt_q == HW'(1));

endmodule

// File: rtl/lock_watch.sv
module lock_watch
    import lw_pkg::*;
#(
    parameter int EDGE_SAMPLES = 2,
    parameter int HOLD_TICKS   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_en,
    input  logic       ms_tick,
    input  logic       err_in,
    input  logic [1:0] mode,
    output logic       det_en,
    output logic       det_n,
    output logic       unlock,
    output logic       lock_ok
);
    localparam int HW = $clog2(HOLD_TICKS + 1);

    lw_state_e     state_q, state_d;
    logic          raw_q;
    logic          win;
    logic          viol;
    logic          expire;
    logic [HW-1:0] hold_cnt;

    assign win = mode[1];

    lw_sampler #(.EDGE_SAMPLES(EDGE_SAMPLES)) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (win),
        .smp_en (smp_en),
        .err_in (err_in),
        .viol   (viol)
    );

    lw_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!win),
        .load   (viol),
        .tick   (ms_tick),
        .cnt_o  (hold_cnt),
        .expire (expire)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            raw_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            raw_q   <= err_in;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (mode == MODE_OFF) begin
            state_d = ST_OFF;
        end else if (mode == MODE_RAW) begin
            state_d = ST_RAW;
        end else begin
            unique case (state_q)
                ST_OFF, ST_RAW: state_d = viol ? ST_HOLD : ST_LOCK;
                ST_LOCK:        state_d = viol ? ST_HOLD : ST_LOCK;
                ST_HOLD:        state_d = viol ? ST_HOLD
                                        : (expire ? ST_LOCK : ST_HOLD);
                default:        state_d = ST_OFF;
            endcase
        end
    end

    // Outputs
    always_comb begin
        det_en  = 1'b0;
        det_n   = 1'b1;
        unlock  = 1'b0;
        lock_ok = 1'b1;
        unique case (state_q)
            ST_OFF: begin
                det_en = 1'b0;
            end
            ST_RAW: begin
                det_en  = 1'b1;
                det_n   = !raw_q;
                unlock  = raw_q;
                lock_ok = !raw_q;
            end
            ST_LOCK: begin
                det_en = 1'b1;
            end
            ST_HOLD: begin
                det_en  = 1'b1;
                det_n   = 1'b0;
                unlock  = 1'b1;
                lock_ok = 1'b0;
            end
            default: begin
                det_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lock_watch_chk.sv
module lock_watch_chk
    import lw_pkg::*;
#(
    parameter int HOLD_TICKS = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [1:0]                       mode,
    input logic                             err_in,
    input logic                             ms_tick,
    input logic                             viol,
    input lw_state_e                        state_q,
    input logic [$clog2(HOLD_TICKS+1)-1:0]  hold_cnt,
    input logic                             det_en,
    input logic                             det_n,
    input logic                             unlock,
    input logic                             lock_ok
);
    localparam int HW = $clog2(HOLD_TICKS + 1);

    logic started;
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    // R1
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_OFF));

    // R2
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (started && mode == MODE_OFF) |=> (!det_en && !unlock && lock_ok));

    // R3
    p_raw_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (started && mode == MODE_RAW) |=> (det_en && det_n == !$past(err_in)));

    // R5
    p_viol_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> (unlock && !det_n && !lock_ok));

    // R7
    p_reload_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> (hold_cnt == HW'(HOLD_TICKS)));

    // R6
    p_hold_tracks_timer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (started && mode[1]) |=> ((state_q == ST_HOLD) == (hold_cnt != '0)));

    // R6
    p_release_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (started && mode[1] && state_q == ST_HOLD && !ms_tick && !viol) |=> unlock);

    // R8
    p_leave_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !mode[1]) |=> (hold_cnt == '0));

endmodule

bind lock_watch lock_watch_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .err_in   (err_in),
    .ms_tick  (ms_tick),
    .viol     (viol),
    .state_q  (state_q),
    .hold_cnt (hold_cnt),
    .det_en   (det_en),
    .det_n    (det_n),
    .unlock   (unlock),
    .lock_ok  (lock_ok)
);

// File: tb/lock_watch_bench.sv
module lock_watch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_en = 1'b0;
    logic       ms_tick = 1'b0;
    logic       err_in = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       det_en, det_n, unlock, lock_ok;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lock_watch u_lock_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_en  (smp_en),
        .ms_tick (ms_tick),
        .err_in  (err_in),
        .mode    (mode),
        .det_en  (det_en),
        .det_n   (det_n),
        .unlock  (unlock),
        .lock_ok (lock_ok)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Check all four outputs at once
    task automatic chk_all(input string req, input logic en, input logic n, input logic ul, input logic ok);
        chk(req, "det_en", det_en, en);
        chk(req, "det_n", det_n, n);
        chk(req, "unlock", unlock, ul);
        chk(req, "lock_ok", lock_ok, ok);
    endtask

    task automatic strobe_smp();
        @(negedge clk) smp_en = 1'b1;
        @(negedge clk) smp_en = 1'b0;
    endtask

    task automatic strobe_ms();
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk) mode = m;
        @(negedge clk);
    endtask

    task automatic make_violation();
        err_in = 1'b0; strobe_smp();
        err_in = 1'b1; strobe_smp(); strobe_smp();
        err_in = 1'b0;
    endtask

    task automatic t_reset();
        chk_all("R1", 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_off();
        set_mode(2'b00);
        err_in = 1'b1;
        strobe_smp(); strobe_smp(); strobe_smp(); strobe_ms();
        chk_all("R2", 1'b0, 1'b1, 1'b0, 1'b1);
        err_in = 1'b0;
    endtask

    task automatic t_raw();
        set_mode(2'b01);
        @(negedge clk) err_in = 1'b1;
        @(negedge clk);
        chk_all("R3", 1'b1, 1'b0, 1'b1, 1'b0);
        err_in = 1'b0;
        @(negedge clk);
        chk_all("R3", 1'b1, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_short();
        set_mode(2'b10);
        chk_all("R8", 1'b1, 1'b1, 1'b0, 1'b1);
        err_in = 1'b1; strobe_smp();
        chk("R4", "unlock after one high strobe", unlock, 1'b0);
        err_in = 1'b0; strobe_smp();
        err_in = 1'b1; strobe_smp();
        err_in = 1'b0; strobe_smp();
        chk("R4", "unlock after split highs", unlock, 1'b0);
    endtask

    task automatic t_violation();
        err_in = 1'b1; strobe_smp();
        chk("R4", "unlock before second strobe", unlock, 1'b0);
        strobe_smp();
        chk_all("R5", 1'b1, 1'b0, 1'b1, 1'b0);
        err_in = 1'b0;
        strobe_ms();
        chk("R6", "unlock after first tick", unlock, 1'b1);
        strobe_ms();
        chk("R6", "unlock after second tick", unlock, 1'b0);
        chk("R6", "lock_ok after hold", lock_ok, 1'b1);
    endtask

    task automatic t_reload();
        set_mode(2'b11);
        make_violation();
        chk("R9", "unlock in mode 11", unlock, 1'b1);
        strobe_ms();
        make_violation();
        strobe_ms();
        chk("R7", "unlock after reload + one tick", unlock, 1'b1);
        // violation and tick on the same clock
        err_in = 1'b1; strobe_smp();
        @(negedge clk) begin smp_en = 1'b1; ms_tick = 1'b1; end
        @(negedge clk) begin smp_en = 1'b0; ms_tick = 1'b0; end
        err_in = 1'b0;
        strobe_ms();
        chk("R7", "unlock after same-cycle reload + one tick", unlock, 1'b1);
        strobe_ms();
        chk("R7", "unlock after full reload count", unlock, 1'b0);
    endtask

    task automatic t_leave();
        set_mode(2'b10);
        make_violation();
        chk("R8", "unlock before leaving", unlock, 1'b1);
        set_mode(2'b00);
        chk_all("R8", 1'b0, 1'b1, 1'b0, 1'b1);
        set_mode(2'b10);
        chk_all("R8", 1'b1, 1'b1, 1'b0, 1'b1);
        // partial run discarded by leaving
        err_in = 1'b1; strobe_smp();
        set_mode(2'b01);
        err_in = 1'b0;
        @(negedge clk) mode = 2'b10;
        err_in = 1'b1; strobe_smp();
        chk("R8", "unlock after run split by mode exit", unlock, 1'b0);
        err_in = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off();
        t_raw();
        t_short();
        t_violation();
        t_reload();
        t_leave();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule